// File: doc/BRIEF.md
# Chunk-Aware Transmit Byte Queue

This block holds outgoing bytes between the logic that produces key events and the serial frame transmitter of a keyboard-side port. Bytes are written in groups: a single make code, a multi-byte break code, an identification reply. The last byte of each group carries a marker. A group is only accepted if all of it fits in the free space. A group that would overflow is thrown away as a whole, and a one-cycle drop pulse reports it.

The transmitter takes one byte at a time through a valid/ready handshake. It then reports either completion or abort for that byte. Storage is released only when the final byte of a group completes. An abort on any byte of a group rewinds the read position to the first byte of that group, so the host receives the whole group again. While the host holds the line inhibited, the transmitter simply takes nothing, and new groups stay queued.

Top module: `chunk_tx_buffer`

## Requirements
- R1: During and directly after reset, `rdValid`, `full` and `dropped` are 0.
- R2: Bytes are offered on `rdData` in the order they were written. Bytes of a group that is still being written (no byte with `wrLast`=1 yet) are never offered: `rdValid` stays 0 while only such bytes are stored.
- R3: Capacity is 16 bytes. A group is stored only if every one of its bytes fits. Otherwise none of it is stored, and `dropped` is 1 for exactly the cycle after the clock edge that takes the group's last byte. `full` is 1 when stored plus partly written bytes total 16.
- R4: A group longer than 4 bytes is discarded whole and reported on `dropped`, in the same way as in R3.
- R5: In the cycle after a handshake (`rdValid` and `rdReady` both 1), `rdValid` is 0, and it stays 0 until `txDone` or `txAbort`.
- R6: `txDone` for the byte in flight moves the offer to the next stored byte. `rdData` stays stable while a byte is in flight.
- R7: `txAbort` for the byte in flight moves the offer back to the first byte of the current group, including bytes of that group already completed.
- R8: Storage held by a group is released only when its last byte completes. Until then, space is not freed for new groups.
- R9: `txDone` or `txAbort` while no byte is in flight has no effect on the offered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 8 | Byte to enqueue |
| wrLast | input | 1 | Marks the final byte of a group |
| wrValid | input | 1 | Write strobe for `wrData`/`wrLast` |
| rdData | output | 8 | Byte offered to the transmitter |
| rdValid | output | 1 | A committed byte is offered |
| rdReady | input | 1 | Transmitter takes the offered byte |
| txDone | input | 1 | Pulse: byte in flight finished |
| txAbort | input | 1 | Pulse: byte in flight aborted by the host |
| full | output | 1 | No free byte slot |
| dropped | output | 1 | Pulse: last write completed a discarded group |

## Verification
The hardest state to reach from the ports is a full queue whose oldest group is partly transmitted. In that state the completed bytes have not yet freed storage, so a new one-byte group must still be refused. The bench fills the queue with four four-byte groups while its transmitter model is paused. It then allows exactly three byte completions and offers a new group, which must be dropped. In the same state it fires stray done and abort pulses and checks that the offered byte does not move. A single further completion must then make room, and the same write must succeed.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic wrLast;
  } ctb_ctl_t;
endpackage

// File: rtl/ctb_datapath.sv
module ctb_datapath #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  ctb_pkg::ctb_ctl_t   ctl,
  input  logic [AW-1:0]       wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [AW-1:0]       rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdLast
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic              lastMem [DEPTH];

  always_ff @(posedge clk) begin
    if (ctl.wrEn) begin
      dataMem[wrAddr] <= wrData;
      lastMem[wrAddr] <= ctl.wrLast;
    end
  end

  assign rdData = dataMem[rdAddr];
  assign rdLast = lastMem[rdAddr];
endmodule

// File: rtl/ctb_control.sv
module ctb_control #(
  parameter int DEPTH     = 16,
  parameter int MAX_CHUNK = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1,
  localparam int LW       = $clog2(MAX_CHUNK + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrLast,
  input  logic              rdReady,
  input  logic              txDone,
  input  logic              txAbort,
  input  logic              rdLast,
  output ctb_pkg::ctb_ctl_t ctl,
  output logic [AW-1:0]     wrAddr,
  output logic [AW-1:0]     rdAddr,
  output logic              rdValid,
  output logic              full,
  output logic              dropped,
  output logic              busy
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [LW-1:0] MAXC_P  = LW'(MAX_CHUNK);

  logic [PW-1:0] wrCommit, wrStage, rdCommit, rdSpec;
  logic [LW-1:0] stageLen;
  logic          dropping;
  logic [PW-1:0] staged;
  logic          fits, accept, take;

  assign staged  = wrStage - rdCommit;
  assign fits    = (staged < DEPTH_P) && (stageLen < MAXC_P);
  assign accept  = wrValid && !dropping && fits;
  assign rdValid = !busy && (rdSpec != wrCommit);
  assign take    = rdValid && rdReady;
  assign full    = (staged == DEPTH_P);

  assign ctl.wrEn   = accept;
  assign ctl.wrLast = wrLast;
  assign wrAddr     = wrStage[AW-1:0];
  assign rdAddr     = rdSpec[AW-1:0];

  // Write side: staging pointer runs ahead, commit on last byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCommit <= '0;
      wrStage  <= '0;
      stageLen <= '0;
      dropping <= 1'b0;
      dropped  <= 1'b0;
    end else begin
      dropped <= 1'b0;
      if (wrValid) begin
        if (wrLast) begin
          stageLen <= '0;
          dropping <= 1'b0;
          if (accept) begin
            wrStage  <= wrStage + 1'b1;
            wrCommit <= wrStage + 1'b1;
          end else begin
            wrStage <= wrCommit;
            dropped <= 1'b1;
          end
        end else if (accept) begin
          wrStage  <= wrStage + 1'b1;
          stageLen <= stageLen + 1'b1;
        end else begin
          dropping <= 1'b1;
          wrStage  <= wrCommit;
          stageLen <= '0;
        end
      end
    end
  end

  // Read side: speculative pointer, rewound to commit pointer on abort
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCommit <= '0;
      rdSpec   <= '0;
      busy     <= 1'b0;
    end else if (busy) begin
      if (txAbort) begin
        rdSpec <= rdCommit;
        busy   <= 1'b0;
      end else if (txDone) begin
        rdSpec <= rdSpec + 1'b1;
        if (rdLast) rdCommit <= rdSpec + 1'b1;
        busy <= 1'b0;
      end
    end else if (take) begin
      busy <= 1'b1;
    end
  end
endmodule

// File: rtl/chunk_tx_buffer.sv
module chunk_tx_buffer #(
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_CHUNK = 4,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  input  logic              wrValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              rdReady,
  input  logic              txDone,
  input  logic              txAbort,
  output logic              full,
  output logic              dropped
);
  ctb_pkg::ctb_ctl_t ctl;
  logic [AW-1:0]     wrAddr, rdAddr;
  logic              rdLast, busyQ;

  ctb_control #(.DEPTH(DEPTH), .MAX_CHUNK(MAX_CHUNK)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrLast(wrLast),
    .rdReady(rdReady), .txDone(txDone), .txAbort(txAbort), .rdLast(rdLast),
    .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr), .rdValid(rdValid),
    .full(full), .dropped(dropped), .busy(busyQ)
  );

  ctb_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .ctl(ctl), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .rdLast(rdLast)
  );
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              wrLast,
  input logic              rdValid,
  input logic              rdReady,
  input logic [DATA_W-1:0] rdData,
  input logic              txDone,
  input logic              txAbort,
  input logic              full,
  input logic              dropped,
  input logic              busy,
  input logic              wrEn
);
  a_r5_hold_after_take: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady) |=> !rdValid);

  a_r3_drop_follows_last: assert property (@(posedge clk) disable iff (!rstN)
    dropped |-> $past(wrValid && wrLast));

  a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !wrEn);

  a_r7_abort_ends_flight: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txAbort) |=> !busy);

  a_r6_data_stable_in_flight: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !txDone && !txAbort) |=> $stable(rdData));
endmodule

bind chunk_tx_buffer ctb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrLast(wrLast),
  .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData),
  .txDone(txDone), .txAbort(txAbort), .full(full), .dropped(dropped),
  .busy(busyQ), .wrEn(ctl.wrEn)
);

// File: tb/sim_chunk_tx_buffer.sv
module sim_chunk_tx_buffer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrLast = 1'b0, wrValid = 1'b0;
  logic [7:0] rdData;
  logic       rdValid, rdReady = 1'b0, txDone = 1'b0, txAbort = 1'b0;
  logic       full, dropped;

  int nTests = 0, nFail = 0;
  int occ = 0;          // committed bytes not yet released (model)
  int budget = 0;       // completions the transmitter model may do
  int attempts = 0;
  int abortAt = -1;
  logic [8:0] expQ[$];  // {last, data}
  logic [8:0] sentQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  chunk_tx_buffer u0 (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrLast(wrLast), .wrValid(wrValid),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady), .txDone(txDone),
    .txAbort(txAbort), .full(full), .dropped(dropped)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  // Driver: writes one group of n bytes base, base+1, ...
  task automatic writeChunk(input int n, input logic [7:0] base, input bit hide);
    bit drop;
    drop = (n > 4) || (occ + n > 16);
    if (!drop) begin
      for (int i = 0; i < n; i++) expQ.push_back({(i == n-1), 8'(base + i)});
      occ += n;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hide && i == n-1) check("R2 partial group hidden", rdValid, 0);
      wrValid = 1'b1; wrData = 8'(base + i); wrLast = (i == n-1);
    end
    @(negedge clk);
    wrValid = 1'b0; wrLast = 1'b0;
    check(n > 4 ? "R4 dropped pulse" : "R3 dropped pulse", dropped, drop ? 1 : 0);
  endtask

  task automatic drain();
    budget = 100000;
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    budget = 0;
  endtask

  // Monitor / transmitter model
  initial begin
    logic [8:0] item;
    forever begin
      @(negedge clk);
      if (budget > 0 && rdValid) begin
        if (expQ.size() == 0) begin
          check("R2 unexpected byte offered", 1, 0);
          item = '0;
        end else begin
          item = expQ[0];
          check("R6 byte order", rdData, item[7:0]);
        end
        rdReady = 1'b1;
        @(negedge clk);
        rdReady = 1'b0;
        check("R5 valid low in flight", rdValid, 0);
        repeat (2) @(negedge clk);
        check("R5 valid still low", rdValid, 0);
        attempts++;
        if (attempts == abortAt) begin
          txAbort = 1'b1;
          @(negedge clk);
          txAbort = 1'b0;
          for (int i = sentQ.size() - 1; i >= 0; i--) expQ.push_front(sentQ[i]);
          sentQ.delete();
        end else begin
          txDone = 1'b1;
          @(negedge clk);
          txDone = 1'b0;
          if (expQ.size() != 0) void'(expQ.pop_front());
          if (item[8]) begin
            occ -= sentQ.size() + 1;
            sentQ.delete();
          end else sentQ.push_back(item);
          budget--;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdValid in reset", rdValid, 0);
    check("R1 full in reset", full, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdValid after reset", rdValid, 0);
    check("R1 full after reset", full, 0);
    check("R1 dropped after reset", dropped, 0);

    // R2: partial group invisible, then ordered delivery
    writeChunk(3, 8'h11, 1'b1);
    check("R2 group visible after last", rdValid, 1);
    drain();

    // R7: abort on second byte of a two-byte group
    abortAt = attempts + 3;
    writeChunk(1, 8'h21, 1'b0);
    writeChunk(2, 8'h31, 1'b0);
    drain();
    check("R7 replay consumed", expQ.size(), 0);

    // R4: oversize group dropped, legal one accepted
    writeChunk(5, 8'h41, 1'b0);
    writeChunk(4, 8'h51, 1'b0);
    drain();

    // R3/R8/R9: full queue with oldest group partly sent
    for (int c = 0; c < 4; c++) writeChunk(4, 8'(8'h60 + 16*c), 1'b0);
    check("R3 full at 16", full, 1);
    writeChunk(1, 8'hA0, 1'b0);
    budget = 3;
    while (budget != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R8 no space before group completes", full, 1);
    writeChunk(1, 8'hA1, 1'b0);
    check("R9 offered before stray pulses", rdData, 8'h63);
    txDone = 1'b1; @(negedge clk); txDone = 1'b0; @(negedge clk);
    check("R9 stray done ignored", rdData, 8'h63);
    txAbort = 1'b1; @(negedge clk); txAbort = 1'b0; @(negedge clk);
    check("R9 stray abort ignored", rdData, 8'h63);
    budget = 1;
    while (budget != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R8 space freed after group", full, 0);
    writeChunk(1, 8'hA2, 1'b0);
    drain();
    check("R6 all bytes delivered", expQ.size(), 0);
    check("R3 empty at end", full, 0);
    finishRun();
  end
endmodule